// File: doc/BRIEF.md
# Byte-Addressed Nonvolatile Store Controller

This block puts a 512-byte persistent-style storage array behind four byte-wide registers on a simple CPU register bus. Software loads a cell address through two address registers, places a byte in the data register and then writes the control register. That control write either fetches the addressed cell into the data register or starts a timed programming cycle. A programming cycle can erase the cell, store a byte in it, erase and store in one pass, or merge the new byte into the old contents by a bitwise OR.

A programming cycle only starts after an arming step. Software first writes the arming bit, then writes the start bit within four clocks. While the cycle runs, the start bit reads back as 1 and the register file ignores every bus write. When the cycle ends, the hardware commits the new cell value and drops the start bit. A level interrupt tells software the store is idle whenever software has enabled it.

The bus is a plain register port: a write takes effect at the clock edge where `bus_we` is high, and `bus_rdata` shows the register selected by `bus_sel` combinationally. There is no back-pressure. Software finds out whether a write was accepted by polling the busy bit or by using the interrupt.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low.
- R2: The registers sit at `bus_sel` 0 (control), 1 (data), 2 (address low) and 3 (address high). The address-high register keeps only bit 0 and reads back with bits 7:1 at zero. The cell address is {address-high bit 0, address low}.
- R3: The control register bits are: bit 0 fetch, bit 1 start/busy, bit 2 arm, bit 3 interrupt enable, bits 5:4 program mode. A control write with bit 0 set loads the addressed cell into the data register, and the new value is readable after that edge. Bit 0 always reads back 0.
- R4: When bits 0 and 1 are both set in one control write, the fetch is performed and no programming cycle starts.
- R5: Mode 00 (erase and store) leaves the cell holding the data register value.
- R6: Mode 01 (erase) leaves the cell holding 0x00.
- R7: Mode 10 (merge) leaves the cell holding the old value ORed with the data register value.
- R8: Mode 11 runs a full programming cycle and leaves the cell unchanged.
- R9: A write with bit 1 set starts a cycle only if a write with bit 2 set happened at one of the 4 preceding clock edges. The arm bit reads 1 for exactly 4 clocks after it is written, then clears by itself.
- R10: Once a cycle has started, bit 1 reads 1 for exactly PROG_CYC clocks and then reads 0. The cell holds its new value from the clock where bit 1 clears.
- R11: While bit 1 reads 1, bus writes to any register have no effect.
- R12: `irq` is high exactly when the interrupt-enable bit is 1 and no programming cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Level interrupt: enabled and idle |

## Verification
The hardest cases to reach from the ports are the edges of the arming window and bus writes that arrive during a programming cycle. The bench puts the start write at a chosen number of clocks after the arm write, and it reads the arm bit on each of those clocks. It then sends writes to every register while the store is busy and reads all of them back after the cycle ends. A sweep that programs and fetches all 512 cells gives each address bit, including the high-register bit, its own observable effect.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PM_ERASE_STORE = 2'b00,
    PM_ERASE       = 2'b01,
    PM_MERGE       = 2'b10,
    PM_NONE        = 2'b11
  } pmode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_ALO  = 2'd2;
  localparam logic [1:0] SEL_AHI  = 2'd3;

  localparam int B_FETCH = 0;
  localparam int B_START = 1;
  localparam int B_ARM   = 2;
  localparam int B_IEN   = 3;
  localparam int B_MODE  = 4;

  localparam logic [7:0] ERASED = 8'h00;
endpackage

// File: rtl/nvs_arm.sv
module nvs_arm #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (set_i)     cnt <= CW'(WIN);
    else if (clr_i)     cnt <= '0;
    else if (cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign armed_o = (cnt != 0);

  a_r9_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIN));
  a_r9_window_decays: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && armed_o) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int PROG_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  pmode_e     mode_i,
  input  logic [7:0] data_i,
  input  logic [7:0] old_i,
  output logic       busy_o,
  output logic       commit_o,
  output logic [7:0] new_o
);
  localparam int CW = $clog2(PROG_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start_i && cnt == 0) cnt <= CW'(PROG_CYC);
    else if (cnt != 0)   cnt <= cnt - 1'b1;
  end

  assign busy_o   = (cnt != 0);
  assign commit_o = (cnt == CW'(1));

  always_comb begin
    unique case (mode_i)
      PM_ERASE_STORE: new_o = data_i;
      PM_ERASE:       new_o = ERASED;
      PM_MERGE:       new_o = old_i | data_i;
      default:        new_o = old_i;
    endcase
  end

  a_r10_ends_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_o) |=> busy_o);
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we_i) begin
      cells[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[addr_i];

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW       = 9,
  parameter int PROG_CYC = 8,
  parameter int ARM_WIN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int HW = AW - 8;

  logic [7:0]    data_q, alo_q;
  logic [HW-1:0] ahi_q;
  logic          ien_q;
  pmode_e        mode_q;
  logic          busy, armed, commit;
  logic [7:0]    cell_old, cell_new;
  logic [AW-1:0] cell_addr;

  logic wr_ok, ctrl_wr, fetch_req, start_req, arm_set;

  assign wr_ok     = bus_we && !busy;
  assign ctrl_wr   = wr_ok && (bus_sel == SEL_CTRL);
  assign fetch_req = ctrl_wr && bus_wdata[B_FETCH];
  assign start_req = ctrl_wr && bus_wdata[B_START] && !bus_wdata[B_FETCH] && armed;
  assign arm_set   = ctrl_wr && bus_wdata[B_ARM] && !start_req;
  assign cell_addr = {ahi_q, alo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      ien_q  <= 1'b0;
      mode_q <= PM_ERASE_STORE;
    end else if (wr_ok) begin
      unique case (bus_sel)
        SEL_CTRL: begin
          ien_q  <= bus_wdata[B_IEN];
          mode_q <= pmode_e'(bus_wdata[B_MODE +: 2]);
          if (bus_wdata[B_FETCH]) data_q <= cell_old;
        end
        SEL_DATA: data_q <= bus_wdata;
        SEL_ALO:  alo_q  <= bus_wdata;
        default:  ahi_q  <= bus_wdata[HW-1:0];
      endcase
    end
  end

  nvs_arm #(.WIN(ARM_WIN)) u_arm (
    .clk(clk), .rst_n(rst_n), .set_i(arm_set), .clr_i(start_req), .armed_o(armed)
  );

  nvs_seq #(.PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_req), .mode_i(mode_q),
    .data_i(data_q), .old_i(cell_old), .busy_o(busy), .commit_o(commit),
    .new_o(cell_new)
  );

  nvs_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(commit), .addr_i(cell_addr),
    .wdata_i(cell_new), .rdata_o(cell_old)
  );

  always_comb begin
    unique case (bus_sel)
      SEL_CTRL: bus_rdata = {2'b00, mode_q, ien_q, armed, busy, 1'b0};
      SEL_DATA: bus_rdata = data_q;
      SEL_ALO:  bus_rdata = alo_q;
      default:  bus_rdata = {{(8-HW){1'b0}}, ahi_q};
    endcase
  end

  assign irq = ien_q && !busy;

  a_r11_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(data_q) && $stable(alo_q) && $stable(ahi_q) && $stable(ien_q)));
  a_r4_fetch_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !busy) |=> !busy);
  a_r9_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  a_r12_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

// File: tb/nvs_ctrl_tb.sv
module nvs_ctrl_tb;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  nvs_ctrl #(.AW(9), .PROG_CYC(P), .ARM_WIN(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    bus_sel = s; #1; v = bus_rdata;
  endtask

  task automatic set_addr(int a);
    wr(2'd2, 8'(a & 255));
    wr(2'd3, 8'(a >> 8));
  endtask

  task automatic fetch(int a, output logic [7:0] v);
    set_addr(a);
    wr(2'd0, 8'h01);
    rd(2'd1, v);
  endtask

  task automatic prog(int a, logic [7:0] d, logic [1:0] m, output int busy_n, output int irq_bad);
    logic [7:0] c;
    set_addr(a);
    wr(2'd1, d);
    wr(2'd0, {2'b00, m, 4'b1100});
    wr(2'd0, {2'b00, m, 4'b1010});
    busy_n = 0; irq_bad = 0;
    rd(2'd0, c);
    while (c[1] && busy_n < 1000) begin
      if (irq) irq_bad++;
      busy_n++;
      @(posedge clk); @(negedge clk);
      rd(2'd0, c);
    end
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bn, ib, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check("R1 reset reg", v, 0);
    end
    check("R1 reset irq", irq, 0);

    wr(2'd3, 8'hFF); rd(2'd3, v); check("R2 addr-high mask", v, 8'h01);
    wr(2'd2, 8'hA5); rd(2'd2, v); check("R2 addr-low", v, 8'hA5);
    wr(2'd0, 8'h08); check("R12 irq enabled idle", irq, 1);
    wr(2'd0, 8'h00); check("R12 irq disabled", irq, 0);

    bad = 0;
    for (int a = 0; a < 512; a++) begin
      prog(a, pat(a), 2'b00, bn, ib);
      if (a == 0) begin
        check("R10 busy length", bn, P);
        check("R12 irq low while busy", ib, 0);
        check("R12 irq high after", irq, 1);
      end else if (bn != P) bad++;
    end
    check("R10 busy length sweep", bad, 0);

    bad = 0;
    for (int a = 0; a < 512; a++) begin
      fetch(a, v);
      if (v != pat(a)) begin
        bad++;
        check("R5 cell content", v, pat(a));
      end
    end
    check("R5 R2 sweep mismatches", bad, 0);
    rd(2'd0, v); check("R3 fetch bit reads 0", v[0], 0);

    prog(5, 8'h0F, 2'b10, bn, ib);
    fetch(5, v); check("R7 merge", v, pat(5) | 8'h0F);
    prog(6, 8'h77, 2'b01, bn, ib);
    fetch(6, v); check("R6 erase", v, 0);
    prog(7, 8'h33, 2'b11, bn, ib);
    check("R8 reserved busy length", bn, P);
    fetch(7, v); check("R8 reserved unchanged", v, pat(7));
    prog(300, 8'hC3, 2'b00, bn, ib);
    fetch(300, v); check("R5 high half store", v, 8'hC3);
    fetch(44, v); check("R2 low alias intact", v, pat(44));

    set_addr(8); wr(2'd1, 8'h5A);
    wr(2'd0, 8'h14);
    wr(2'd0, 8'h13);
    rd(2'd1, v); check("R4 fetch wins data", v, pat(8));
    rd(2'd0, v); check("R4 no start", v[1], 0);
    repeat (P + 2) @(negedge clk);
    fetch(8, v); check("R4 cell untouched", v, pat(8));

    set_addr(9); wr(2'd1, 8'h00);
    wr(2'd0, 8'h14);
    for (int i = 0; i < 4; i++) begin
      rd(2'd0, v); check("R9 arm visible", v[2], 1);
      @(posedge clk); @(negedge clk);
    end
    rd(2'd0, v); check("R9 arm expired", v[2], 0);
    wr(2'd0, 8'h12);
    rd(2'd0, v); check("R9 late start ignored", v[1], 0);
    fetch(9, v); check("R9 cell kept", v, pat(9));

    set_addr(10); wr(2'd1, 8'h55);
    wr(2'd0, 8'h04);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h02);
    rd(2'd0, v); check("R9 start at window edge", v[1], 1);
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h99);
    wr(2'd0, 8'h18);
    repeat (P) @(negedge clk);
    rd(2'd0, v); check("R11 ctrl unchanged", v, 8'h00);
    rd(2'd2, v); check("R11 addr-low unchanged", v, 8'd10);
    rd(2'd3, v); check("R11 addr-high unchanged", v, 0);
    rd(2'd1, v); check("R11 data unchanged", v, 8'h55);
    check("R12 irq stays off", irq, 0);
    fetch(10, v); check("R11 cell stored", v, 8'h55);
    fetch(32 + 256, v); check("R11 other cell", v, pat(288));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule